// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers 64 level-sensitive interrupt inputs and turns them into two processor request lines: a normal request and a fast request. Each input has an enable bit, a routing bit that sends it to the normal or the fast path, a 4-bit priority, and a software force bit that drives it as if its input were high. A 32-bit register bus with byte addresses and single-cycle read and write strobes gives access to all of this state.

For the normal path, a vector register names the pending source that should be serviced first. It ranks sources by priority, and on equal priority the higher source number wins. A global threshold gates the normal request line. Fast sources have their own vector register, which names the highest-numbered pending fast source. Both vectors are computed combinationally from live state. A service routine can read the vector repeatedly until it sees the idle code, and it never writes an acknowledge.

Top module: `irqc_top`

## Requirements
- R1: After reset the threshold register (0x04, bits [4:0]) reads 0x1F. The control word (0x00), all enables, routing bits, force bits and priority words read 0. Both request lines are low.
- R2: A bus write of value v to 0x08 sets the enable bit of source v, and a write to 0x0C clears it. A value of 64 or more changes no enable bit.
- R3: Enable bits for sources 32–63 are at 0x10 and those for sources 0–31 are at 0x14. Bit i of each word covers source 32+i or i. Both are read/write.
- R4: A source is pending when (input OR force bit) AND enable. With routing bit 0 (0x18 high, 0x1C low) it is normal-pending, and with routing bit 1 it is fast-pending. Normal-pending state reads at 0x58/0x5C and fast-pending state at 0x60/0x64, high half first.
- R5: Force bits are read/write at 0x50 (sources 32–63) and 0x54 (sources 0–31). A set force bit makes its source pending with its input low.
- R6: Source n's priority is field [4*(n%8)+3 : 4*(n%8)] of priority word n/8. Word k is at byte address 0x20 + 4*(7−k), so 0x20 holds sources 56–63 and 0x3C holds sources 0–7.
- R7: The normal vector at 0x40 returns, in bits [31:16], the normal-pending source with the largest priority. A tie goes to the higher source number. The threshold does not affect it, and bits [15:0] read 0.
- R8: When no source is normal-pending, bits [31:16] of 0x40 read 0xFFFF.
- R9: irq_o is high exactly when some source is normal-pending and the winner's priority is strictly greater than the 5-bit threshold. A threshold of 0x1F therefore blocks the line.
- R10: fiq_o is high exactly when some source is fast-pending. Bits [31:16] of 0x44 hold the highest-numbered fast-pending source, or 0xFFFF if there is none, and bits [15:0] read 0.
- R11: 0x48 and 0x4C return the raw inputs for sources 32–63 and 0–31.
- R12: Read data appears on bus_rdata on the clock edge that samples bus_rd. The vectors and request lines follow input, enable and force changes with no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_in | input | 64 | Level-sensitive interrupt inputs |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Assertions check the following on every cycle:
- Each vector names a source that is actually pending, and the idle code appears only when nothing is pending.
- Enable-by-number writes set or clear the addressed bit, and out-of-range values leave the enables unchanged.
- A threshold of 0x1F keeps irq_o low.
- fiq_o agrees with the fast arbiter.

The bench scenarios cover what a single-cycle property cannot:
- the reversed word addressing for every one of the 64 sources;
- the tie-break order and the exact threshold boundary;
- the force path and routing split across both pending registers;
- the vector returning to 0xFFFF once inputs drop.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned NSRC      = 64;
    localparam int unsigned IDX_W     = $clog2(NSRC);
    localparam int unsigned PRIO_W    = 4;
    localparam int unsigned REG_W     = 32;
    localparam int unsigned PER_WORD  = REG_W / PRIO_W;
    localparam int unsigned NWORDS    = NSRC / PER_WORD;
    localparam int unsigned HALF      = NSRC / 2;
    localparam int unsigned THR_W     = PRIO_W + 1;

    localparam logic [7:0] A_CTRL   = 8'h00;
    localparam logic [7:0] A_THR    = 8'h04;
    localparam logic [7:0] A_ENNUM  = 8'h08;
    localparam logic [7:0] A_DISNUM = 8'h0C;
    localparam logic [7:0] A_ENH    = 8'h10;
    localparam logic [7:0] A_ENL    = 8'h14;
    localparam logic [7:0] A_RTH    = 8'h18;
    localparam logic [7:0] A_RTL    = 8'h1C;
    localparam logic [7:0] A_NVEC   = 8'h40;
    localparam logic [7:0] A_FVEC   = 8'h44;
    localparam logic [7:0] A_SRCH   = 8'h48;
    localparam logic [7:0] A_SRCL   = 8'h4C;
    localparam logic [7:0] A_FRCH   = 8'h50;
    localparam logic [7:0] A_FRCL   = 8'h54;
    localparam logic [7:0] A_NPH    = 8'h58;
    localparam logic [7:0] A_NPL    = 8'h5C;
    localparam logic [7:0] A_FPH    = 8'h60;
    localparam logic [7:0] A_FPL    = 8'h64;

    localparam logic [15:0]      VEC_IDLE = 16'hFFFF;
    localparam logic [THR_W-1:0] THR_RST  = 5'h1F;

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  idx;
        logic [PRIO_W-1:0] prio;
    } win_t;

    // Priority words occupy 0x20..0x3C, highest word at lowest address.
    function automatic logic is_prio_addr(input logic [7:0] a);
        return (a[7:5] == 3'b001) && (a[1:0] == 2'b00);
    endfunction

    function automatic logic [2:0] prio_word_of(input logic [7:0] a);
        return ~a[4:2];
    endfunction

    function automatic logic [REG_W-1:0] vec_word(input win_t w);
        logic [15:0] code;
        code = w.valid ? 16'(w.idx) : VEC_IDLE;
        return {code, 16'h0000};
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [7:0]               addr,
    input  logic [REG_W-1:0]         wdata,
    output logic [REG_W-1:0]         ctrl,
    output logic [THR_W-1:0]         thr,
    output logic [NSRC-1:0]          en,
    output logic [NSRC-1:0]          route,
    output logic [NSRC-1:0]          frc,
    output logic [NWORDS*REG_W-1:0]  prio_flat
);

    logic [NWORDS-1:0][REG_W-1:0] pwords;
    logic                         num_ok;

    assign num_ok    = (wdata < REG_W'(NSRC));
    assign prio_flat = pwords;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            thr    <= THR_RST;
            en     <= '0;
            route  <= '0;
            frc    <= '0;
            pwords <= '0;
        end else if (wr_en) begin
            if (is_prio_addr(addr)) begin
                pwords[prio_word_of(addr)] <= wdata;
            end else begin
                case (addr)
                    A_CTRL:   ctrl <= wdata;
                    A_THR:    thr  <= wdata[THR_W-1:0];
                    A_ENNUM:  if (num_ok) en[wdata[IDX_W-1:0]] <= 1'b1;
                    A_DISNUM: if (num_ok) en[wdata[IDX_W-1:0]] <= 1'b0;
                    A_ENH:    en[NSRC-1:HALF]    <= wdata;
                    A_ENL:    en[HALF-1:0]       <= wdata;
                    A_RTH:    route[NSRC-1:HALF] <= wdata;
                    A_RTL:    route[HALF-1:0]    <= wdata;
                    A_FRCH:   frc[NSRC-1:HALF]   <= wdata;
                    A_FRCL:   frc[HALF-1:0]      <= wdata;
                    default:  ;
                endcase
            end
        end
    end

    p_thr_reset_r1: assert property (@(posedge clk)
        rst |=> (thr == THR_RST && en == '0 && route == '0));

    p_ennum_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_ENNUM && wdata < REG_W'(NSRC))
        |=> en[$past(wdata[IDX_W-1:0])]);

    p_disnum_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_DISNUM && wdata < REG_W'(NSRC))
        |=> !en[$past(wdata[IDX_W-1:0])]);

    p_num_oob_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == A_ENNUM || addr == A_DISNUM) && wdata >= REG_W'(NSRC))
        |=> $stable(en));

endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
    import irqc_pkg::*;
#(
    parameter bit USE_PRIO = 1'b1
)(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NSRC-1:0]          pend,
    input  logic [NWORDS*REG_W-1:0]  prio_flat,
    output win_t                     win
);

    logic [NSRC*PRIO_W-1:0] eff_prio;

    generate
        if (USE_PRIO) begin : g_ranked
            assign eff_prio = prio_flat;
        end else begin : g_by_number
            logic unused_prio;
            assign unused_prio = ^prio_flat;
            assign eff_prio    = '0;
        end
    endgenerate

    // Ascending scan with >= lets a later (higher-numbered) source take ties.
    always_comb begin
        win = '0;
        for (int n = 0; n < NSRC; n++) begin
            if (pend[n] && (eff_prio[n*PRIO_W +: PRIO_W] >= win.prio)) begin
                win.valid = 1'b1;
                win.idx   = IDX_W'(n);
                win.prio  = eff_prio[n*PRIO_W +: PRIO_W];
            end
        end
    end

    p_win_pending_r7: assert property (@(posedge clk) disable iff (rst)
        win.valid |-> pend[win.idx]);

    p_idle_only_empty_r8: assert property (@(posedge clk) disable iff (rst)
        !win.valid |-> (pend == '0));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [63:0]       src_in,
    output logic              irq_o,
    output logic              fiq_o
);

    logic [REG_W-1:0]         ctrl;
    logic [THR_W-1:0]         thr;
    logic [NSRC-1:0]          en, route, frc;
    logic [NWORDS*REG_W-1:0]  prio_flat;
    logic [NSRC-1:0]          live, npend, fpend;
    win_t                     nwin, fwin;
    logic [REG_W-1:0]         rd_mux;

    irqc_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .ctrl      (ctrl),
        .thr       (thr),
        .en        (en),
        .route     (route),
        .frc       (frc),
        .prio_flat (prio_flat)
    );

    assign live  = (src_in | frc) & en;
    assign npend = live & ~route;
    assign fpend = live &  route;

    irqc_arb #(.USE_PRIO(1'b1)) u_norm_arb (
        .clk       (clk),
        .rst       (rst),
        .pend      (npend),
        .prio_flat (prio_flat),
        .win       (nwin)
    );

    irqc_arb #(.USE_PRIO(1'b0)) u_fast_arb (
        .clk       (clk),
        .rst       (rst),
        .pend      (fpend),
        .prio_flat (prio_flat),
        .win       (fwin)
    );

    assign irq_o = nwin.valid && (THR_W'(nwin.prio) > thr);
    assign fiq_o = |fpend;

    always_comb begin
        rd_mux = '0;
        if (is_prio_addr(bus_addr)) begin
            rd_mux = prio_flat[prio_word_of(bus_addr)*REG_W +: REG_W];
        end else begin
            case (bus_addr)
                A_CTRL:  rd_mux = ctrl;
                A_THR:   rd_mux = REG_W'(thr);
                A_ENH:   rd_mux = en[NSRC-1:HALF];
                A_ENL:   rd_mux = en[HALF-1:0];
                A_RTH:   rd_mux = route[NSRC-1:HALF];
                A_RTL:   rd_mux = route[HALF-1:0];
                A_NVEC:  rd_mux = vec_word(nwin);
                A_FVEC:  rd_mux = vec_word(fwin);
                A_SRCH:  rd_mux = src_in[NSRC-1:HALF];
                A_SRCL:  rd_mux = src_in[HALF-1:0];
                A_FRCH:  rd_mux = frc[NSRC-1:HALF];
                A_FRCL:  rd_mux = frc[HALF-1:0];
                A_NPH:   rd_mux = npend[NSRC-1:HALF];
                A_NPL:   rd_mux = npend[HALF-1:0];
                A_FPH:   rd_mux = fpend[NSRC-1:HALF];
                A_FPL:   rd_mux = fpend[HALF-1:0];
                default: rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    p_thr_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        thr[PRIO_W] |-> !irq_o);

    p_irq_needs_pending_r9: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (npend != '0));

    p_fiq_has_vector_r10: assert property (@(posedge clk) disable iff (rst)
        fiq_o == fwin.valid);

    p_paths_disjoint_r4: assert property (@(posedge clk) disable iff (rst)
        !(nwin.valid && fwin.valid && nwin.idx == fwin.idx));

endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_addr;
    logic        bus_wr, bus_rd;
    logic [31:0] bus_wdata, bus_rdata;
    logic [63:0] src_in;
    logic        irq_o, fiq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irqc_top u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_in(src_in), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [7:0] pw_addr(input int src);
        return 8'(32'h20 + 4 * (7 - src / 8));
    endfunction

    function automatic logic [31:0] vec_of(input int src);
        return (src < 0) ? 32'hFFFF_0000 : {16'(src), 16'h0000};
    endfunction

    initial begin
        logic [31:0] d;
        logic [63:0] exp_en;
        rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_wdata = '0; src_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h04, d); chk("R1 threshold", d, 32'h1F);
        rd(8'h00, d); chk("R1 control", d, 32'h0);
        rd(8'h14, d); chk("R1 enable low", d, 32'h0);
        rd(8'h18, d); chk("R1 route high", d, 32'h0);
        rd(8'h2C, d); chk("R1 prio word", d, 32'h0);
        chk("R1 irq", 32'(irq_o), 32'h0);
        chk("R1 fiq", 32'(fiq_o), 32'h0);
        rd(8'h40, d); chk("R8 idle normal vector", d, 32'hFFFF_0000);
        rd(8'h44, d); chk("R10 idle fast vector", d, 32'hFFFF_0000);

        // R2/R3 by-number sweep over every source
        for (int n = 0; n < 64; n++) begin
            exp_en = 64'(1) << n;
            wr(8'h08, 32'(n));
            rd(8'h10, d); chk("R2 enable-by-number high", d, exp_en[63:32]);
            rd(8'h14, d); chk("R2 enable-by-number low", d, exp_en[31:0]);
            wr(8'h0C, 32'(n));
            rd(8'h14, d); chk("R2 disable-by-number low", d, 32'h0);
            rd(8'h10, d); chk("R2 disable-by-number high", d, 32'h0);
        end
        wr(8'h08, 32'd69);
        rd(8'h14, d); chk("R2 out-of-range enable ignored", d, 32'h0);
        rd(8'h10, d); chk("R2 out-of-range enable ignored", d, 32'h0);

        // R3/R6/R7 reversed priority words: all pending at prio 0, raise one
        wr(8'h04, 32'h0);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        src_in = '1;
        rd(8'h40, d); chk("R7 tie at equal prio goes to 63", d, vec_of(63));
        chk("R9 prio 0 not above threshold 0", 32'(irq_o), 32'h0);
        for (int s = 0; s < 64; s++) begin
            wr(pw_addr(s), 32'h5 << (4 * (s % 8)));
            rd(8'h40, d); chk("R6 reversed word addressing", d, vec_of(s));
            chk("R9 prio 5 above threshold 0", 32'(irq_o), 32'h1);
            wr(pw_addr(s), 32'h0);
        end

        // R7 tie-break between equal non-zero priorities
        wr(8'h38, 32'h7 << 8);
        wr(8'h34, 32'h7 << 16);
        rd(8'h40, d); chk("R7 tie 10 vs 20", d, vec_of(20));
        wr(8'h20, 32'h7 << 16);
        rd(8'h40, d); chk("R7 tie adds 60", d, vec_of(60));
        wr(8'h20, 32'h3 << 16);
        rd(8'h40, d); chk("R7 lower prio 60 loses", d, vec_of(20));
        wr(8'h20, 32'h7 << 16);

        // R9 threshold boundary
        wr(8'h04, 32'h7); chk("R9 threshold equal blocks", 32'(irq_o), 32'h0);
        wr(8'h04, 32'h6); chk("R9 threshold below passes", 32'(irq_o), 32'h1);
        wr(8'h04, 32'h1F); chk("R9 threshold 0x1F blocks", 32'(irq_o), 32'h0);
        rd(8'h40, d); chk("R7 vector ignores threshold", d, vec_of(60));
        wr(8'h04, 32'h0);

        // R4/R10 routing to the fast path
        wr(8'h18, 32'h1 << 8);
        wr(8'h1C, 32'h1 << 7);
        chk("R10 fiq", 32'(fiq_o), 32'h1);
        rd(8'h44, d); chk("R10 fast vector highest number", d, vec_of(40));
        rd(8'h60, d); chk("R4 fast pending high", d, 32'h100);
        rd(8'h64, d); chk("R4 fast pending low", d, 32'h80);
        rd(8'h58, d); chk("R4 normal pending high", d, 32'hFFFF_FEFF);
        rd(8'h40, d); chk("R4 normal vector unaffected", d, vec_of(60));
        wr(8'h18, 32'h0);
        rd(8'h44, d); chk("R10 fast vector after high cleared", d, vec_of(7));

        // R11 raw inputs
        src_in = 64'hDEAD_BEEF_0123_4567;
        rd(8'h48, d); chk("R11 source high", d, 32'hDEAD_BEEF);
        rd(8'h4C, d); chk("R11 source low", d, 32'h0123_4567);

        // R12/R8 vector follows inputs with no acknowledge
        wr(8'h1C, 32'h0);
        src_in = '0;
        rd(8'h40, d); chk("R12 vector idle after inputs drop", d, 32'hFFFF_0000);
        rd(8'h44, d); chk("R8 fast vector idle", d, 32'hFFFF_0000);
        chk("R12 irq low", 32'(irq_o), 32'h0);
        chk("R10 fiq low", 32'(fiq_o), 32'h0);

        // R5 force path
        wr(8'h54, 32'h8);
        rd(8'h54, d); chk("R5 force readback", d, 32'h8);
        rd(8'h40, d); chk("R5 forced source wins", d, vec_of(3));
        rd(8'h5C, d); chk("R5 forced pending low", d, 32'h8);
        wr(8'h0C, 32'd3);
        rd(8'h40, d); chk("R5 disabled forced source idle", d, 32'hFFFF_0000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule